// File: doc/BRIEF.md
# MMU Fault Classifier and Exception Entry

This block sits right after an address-translation lookup. It takes the lookup outcome and turns it into one precise exception. The lookup outcome is a hit flag, the matching way, and that way's valid and dirty bits. The block also takes the access direction, an address-error flag and a flag marking the last instructions of a hardware repeat loop. It sees the virtual address, the current address-space identifier, and the current program counter, status word and vector base.

When a fault request is accepted, the block loads a set of capture registers for the handler: the fault address, the page-table-entry-high image, the matched way, the saved program counter, the saved status word and an event code. In the same edge it produces the updated status word, with the block, mode and bank bits forced on, and the handler entry address. The cycle after acceptance is marked by a one-cycle `excTaken` pulse.

Top module: `mmuexc_unit`

## Requirements
- R1: After reset every capture output reads zero: `faultAddr`, `pteHi`, `rcWay`, `savedPc`, `savedSr`, `evtCode`, `srOut`, `excTarget`. `excTaken` is also 0.
- R2: An invalid-entry fault is a hit (hitFlag=1) with entryValid=0. It gives event code 0x040 on a read (isWrite=0) and 0x060 on a write (isWrite=1).
- R3: An initial-page-write fault is a write that hits a valid entry with entryDirty=0. It gives event code 0x080. A read, or a write to a dirty page, that hits a valid entry raises nothing.
- R4: Faults are ranked address error, then miss (hitFlag=0), then invalid, then clean-page write, and only the top one is taken. An address error gives 0x0E0 on a read and 0x100 on a write. A miss gives 0x040 on a read and 0x060 on a write.
- R5: Every taken fault loads all 32 bits of `vAddr` into `faultAddr`.
- R6: Miss, invalid and clean-page-write faults load `pteHi` with `vAddr[31:10]` in bits 31..10, zero in bits 9..8 and `curAsid` in bits 7..0. An address error leaves `pteHi` unchanged.
- R7: Invalid and clean-page-write faults load `hitWay` into `rcWay`. Miss and address-error faults leave `rcWay` unchanged.
- R8: When loopTail=1 with an address-error, miss or invalid fault, the event code is 0x070 and `savedPc` gets `curPc` with bit 0 forced to 1, which marks it as not restartable. A clean-page-write fault ignores loopTail.
- R9: Every taken fault copies `curSr` into `savedSr`. Outside the loop-tail case it copies `curPc` unchanged into `savedPc`.
- R10: On a taken fault, `srOut` becomes `curSr` with bits 28 (block), 30 (mode) and 29 (bank) set, and `excTarget` becomes `vecBase + 0x100`, taken modulo 2^32.
- R11: `excTaken` is high for exactly the one cycle after the edge that accepts a fault. A request presented while `excTaken` is high is ignored.
- R12: A request with curSr bit 28 (block) already set raises no pulse and leaves every capture output unchanged.
- R13: A request with no fault raises no pulse and leaves every capture output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Lookup result present this cycle |
| hitFlag | input | 1 | Address comparison matched an entry |
| hitWay | input | 2 | Way that matched |
| entryValid | input | 1 | Valid bit of matching entry |
| entryDirty | input | 1 | Dirty bit of matching entry |
| isWrite | input | 1 | Access is a store |
| addrErr | input | 1 | CPU address error on this access |
| loopTail | input | 1 | Access lies in a repeat-loop tail |
| vAddr | input | 32 | Virtual address of the access |
| curAsid | input | 8 | Current address-space identifier |
| curPc | input | 32 | PC of the accessing instruction |
| curSr | input | 32 | Current status word |
| vecBase | input | 32 | Vector base |
| excTaken | output | 1 | One-cycle exception entry pulse |
| excTarget | output | 32 | Handler entry address |
| srOut | output | 32 | Status word after entry |
| faultAddr | output | 32 | Captured fault address |
| pteHi | output | 32 | Captured page number and ASID |
| rcWay | output | 2 | Captured way |
| savedPc | output | 32 | Saved PC |
| savedSr | output | 32 | Saved status word |
| evtCode | output | 12 | Event code |

## Verification
A misranked or misclassified fault shows up as the wrong `evtCode`, or as a missing or spurious `excTaken`, one cycle after the request edge. A wrong capture enable shows up in the same cycle. It appears as `pteHi` or `rcWay` changing when it should hold, or holding a stale value when it should load. A capture that leaks through while blocked or fault-free shows up only as changed outputs with no pulse. For that reason the bench compares every capture output after every request against a running model of its expected contents.

// File: rtl/mmuexc_pkg.sv
package mmuexc_pkg;
  localparam int EVT_W = 12;

  localparam logic [EVT_W-1:0] EVT_TLB_RD  = 12'h040;
  localparam logic [EVT_W-1:0] EVT_TLB_WR  = 12'h060;
  localparam logic [EVT_W-1:0] EVT_LOOP    = 12'h070;
  localparam logic [EVT_W-1:0] EVT_FIRSTWR = 12'h080;
  localparam logic [EVT_W-1:0] EVT_ADE_RD  = 12'h0E0;
  localparam logic [EVT_W-1:0] EVT_ADE_WR  = 12'h100;

  typedef enum logic [2:0] {
    FK_NONE, FK_ADDR, FK_MISS, FK_INVALID, FK_CLEAN
  } fault_kind_e;

  typedef struct packed {
    logic             take;
    logic             capPte;
    logic             capWay;
    logic             markPc;
    logic [EVT_W-1:0] code;
  } exc_strobe_t;
endpackage

// File: rtl/mmuexc_ctrl.sv
module mmuexc_ctrl
  import mmuexc_pkg::*;
#(
  parameter int SR_W   = 32,
  parameter int BL_BIT = 28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        hitFlag,
  input  logic        entryValid,
  input  logic        entryDirty,
  input  logic        isWrite,
  input  logic        addrErr,
  input  logic        loopTail,
  input  logic [SR_W-1:0] curSr,
  output exc_strobe_t strb,
  output logic        excTaken
);
  fault_kind_e kind;
  logic        tailCase;
  logic        take;

  always_comb begin
    if (addrErr)                        kind = FK_ADDR;
    else if (!hitFlag)                  kind = FK_MISS;
    else if (!entryValid)               kind = FK_INVALID;
    else if (isWrite && !entryDirty)    kind = FK_CLEAN;
    else                                kind = FK_NONE;
  end

  assign tailCase = loopTail && (kind == FK_ADDR || kind == FK_MISS || kind == FK_INVALID);
  assign take     = reqValid && (kind != FK_NONE) && !curSr[BL_BIT] && !excTaken;

  always_comb begin
    strb        = '0;
    strb.take   = take;
    strb.capPte = take && (kind != FK_ADDR);
    strb.capWay = take && (kind == FK_INVALID || kind == FK_CLEAN);
    strb.markPc = tailCase;
    if (tailCase) strb.code = EVT_LOOP;
    else begin
      unique case (kind)
        FK_ADDR:             strb.code = isWrite ? EVT_ADE_WR : EVT_ADE_RD;
        FK_MISS, FK_INVALID: strb.code = isWrite ? EVT_TLB_WR : EVT_TLB_RD;
        FK_CLEAN:            strb.code = EVT_FIRSTWR;
        default:             strb.code = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) excTaken <= 1'b0;
    else        excTaken <= take;
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    excTaken |=> !excTaken);                                            // R11
  AST_BLOCKED_NOPULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && curSr[BL_BIT]) |=> !excTaken);                         // R12
  AST_CLEAN_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && hitFlag && entryValid && entryDirty && !addrErr) |=> !excTaken); // R13
endmodule

// File: rtl/mmuexc_dp.sv
module mmuexc_dp
  import mmuexc_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int ASID_W   = 8,
  parameter int WAY_W    = 2,
  parameter int SR_W     = 32,
  parameter int PAGE_LSB = 10,
  parameter int BL_BIT   = 28,
  parameter int RB_BIT   = 29,
  parameter int MD_BIT   = 30,
  parameter int VEC_OFS  = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  exc_strobe_t       strb,
  input  logic              excTaken,
  input  logic [WAY_W-1:0]  hitWay,
  input  logic [VA_W-1:0]   vAddr,
  input  logic [ASID_W-1:0] curAsid,
  input  logic [VA_W-1:0]   curPc,
  input  logic [SR_W-1:0]   curSr,
  input  logic [VA_W-1:0]   vecBase,
  output logic [VA_W-1:0]   excTarget,
  output logic [SR_W-1:0]   srOut,
  output logic [VA_W-1:0]   faultAddr,
  output logic [VA_W-1:0]   pteHi,
  output logic [WAY_W-1:0]  rcWay,
  output logic [VA_W-1:0]   savedPc,
  output logic [SR_W-1:0]   savedSr,
  output logic [EVT_W-1:0]  evtCode
);
  localparam logic [SR_W-1:0] SR_MASK =
    (SR_W'(1) << BL_BIT) | (SR_W'(1) << RB_BIT) | (SR_W'(1) << MD_BIT);
  localparam logic [VA_W-1:0] OFS = VA_W'(VEC_OFS);

  logic [VA_W-1:0] pteVal;
  logic [VA_W-1:0] pcVal;

  always_comb begin
    pteVal                    = '0;
    pteVal[VA_W-1:PAGE_LSB]   = vAddr[VA_W-1:PAGE_LSB];
    pteVal[ASID_W-1:0]        = curAsid;
  end

  always_comb begin
    pcVal = curPc;
    if (strb.markPc) pcVal[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      excTarget <= '0;
      srOut     <= '0;
      faultAddr <= '0;
      savedPc   <= '0;
      savedSr   <= '0;
      evtCode   <= '0;
    end else if (strb.take) begin
      excTarget <= vecBase + OFS;
      srOut     <= curSr | SR_MASK;
      faultAddr <= vAddr;
      savedPc   <= pcVal;
      savedSr   <= curSr;
      evtCode   <= strb.code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           pteHi <= '0;
    else if (strb.capPte) pteHi <= pteVal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           rcWay <= '0;
    else if (strb.capWay) rcWay <= hitWay;
  end

  AST_VECTOR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    excTaken |-> (excTarget == $past(vecBase) + OFS));                  // R10
  AST_SR_BITS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    excTaken |-> (srOut[BL_BIT] && srOut[MD_BIT] && srOut[RB_BIT]));    // R10
  AST_SR_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    excTaken |-> (savedSr == $past(curSr)));                            // R9
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    excTaken |-> (faultAddr == $past(vAddr)));                          // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !excTaken |-> ($stable(faultAddr) && $stable(savedSr) && $stable(evtCode))); // R12
endmodule

// File: rtl/mmuexc_unit.sv
module mmuexc_unit
  import mmuexc_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int ASID_W   = 8,
  parameter int WAYS     = 4,
  parameter int SR_W     = 32,
  parameter int PAGE_LSB = 10,
  localparam int WAY_W   = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              hitFlag,
  input  logic [WAY_W-1:0]  hitWay,
  input  logic              entryValid,
  input  logic              entryDirty,
  input  logic              isWrite,
  input  logic              addrErr,
  input  logic              loopTail,
  input  logic [VA_W-1:0]   vAddr,
  input  logic [ASID_W-1:0] curAsid,
  input  logic [VA_W-1:0]   curPc,
  input  logic [SR_W-1:0]   curSr,
  input  logic [VA_W-1:0]   vecBase,
  output logic              excTaken,
  output logic [VA_W-1:0]   excTarget,
  output logic [SR_W-1:0]   srOut,
  output logic [VA_W-1:0]   faultAddr,
  output logic [VA_W-1:0]   pteHi,
  output logic [WAY_W-1:0]  rcWay,
  output logic [VA_W-1:0]   savedPc,
  output logic [SR_W-1:0]   savedSr,
  output logic [EVT_W-1:0]  evtCode
);
  localparam int BL_BIT = 28;
  localparam int RB_BIT = 29;
  localparam int MD_BIT = 30;

  exc_strobe_t strb;

  mmuexc_ctrl #(.SR_W(SR_W), .BL_BIT(BL_BIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .hitFlag(hitFlag),
    .entryValid(entryValid), .entryDirty(entryDirty), .isWrite(isWrite),
    .addrErr(addrErr), .loopTail(loopTail), .curSr(curSr),
    .strb(strb), .excTaken(excTaken)
  );

  mmuexc_dp #(
    .VA_W(VA_W), .ASID_W(ASID_W), .WAY_W(WAY_W), .SR_W(SR_W),
    .PAGE_LSB(PAGE_LSB), .BL_BIT(BL_BIT), .RB_BIT(RB_BIT), .MD_BIT(MD_BIT),
    .VEC_OFS('h100)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .excTaken(excTaken),
    .hitWay(hitWay), .vAddr(vAddr), .curAsid(curAsid), .curPc(curPc),
    .curSr(curSr), .vecBase(vecBase), .excTarget(excTarget), .srOut(srOut),
    .faultAddr(faultAddr), .pteHi(pteHi), .rcWay(rcWay), .savedPc(savedPc),
    .savedSr(savedSr), .evtCode(evtCode)
  );
endmodule

// File: tb/mmuexc_unit_bench.sv
module mmuexc_unit_bench;
  logic        clk = 0, rst_n = 0;
  logic        reqValid = 0, hitFlag = 0, entryValid = 0, entryDirty = 0;
  logic        isWrite = 0, addrErr = 0, loopTail = 0;
  logic [1:0]  hitWay = 0;
  logic [31:0] vAddr = 0, curPc = 0, curSr = 0, vecBase = 0;
  logic [7:0]  curAsid = 0;
  logic        excTaken;
  logic [31:0] excTarget, srOut, faultAddr, pteHi, savedPc, savedSr;
  logic [1:0]  rcWay;
  logic [11:0] evtCode;

  int nTests = 0, nFail = 0;
  logic [31:0] eTgt = 0, eSrOut = 0, eFault = 0, ePte = 0, ePc = 0, eSr = 0;
  logic [1:0]  eWay = 0;
  logic [11:0] eCode = 0;

  always #2 clk = ~clk;

  mmuexc_unit u_mmuexc_unit (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .hitFlag(hitFlag),
    .hitWay(hitWay), .entryValid(entryValid), .entryDirty(entryDirty),
    .isWrite(isWrite), .addrErr(addrErr), .loopTail(loopTail), .vAddr(vAddr),
    .curAsid(curAsid), .curPc(curPc), .curSr(curSr), .vecBase(vecBase),
    .excTaken(excTaken), .excTarget(excTarget), .srOut(srOut),
    .faultAddr(faultAddr), .pteHi(pteHi), .rcWay(rcWay), .savedPc(savedPc),
    .savedSr(savedSr), .evtCode(evtCode)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 none, 1 addr, 2 miss, 3 invalid, 4 clean write
  function automatic int classify(logic ae, logic h, logic v, logic d, logic w);
    if (ae) return 1;
    if (!h) return 2;
    if (!v) return 3;
    if (w && !d) return 4;
    return 0;
  endfunction

  task automatic checkAll(string tag);
    chk({tag, " evtCode"}, {20'h0, evtCode}, {20'h0, eCode});
    chk("R5 faultAddr", faultAddr, eFault);
    chk("R6 pteHi", pteHi, ePte);
    chk("R7 rcWay", {30'h0, rcWay}, {30'h0, eWay});
    chk("R9 savedPc", savedPc, ePc);
    chk("R9 savedSr", savedSr, eSr);
    chk("R10 srOut", srOut, eSrOut);
    chk("R10 excTarget", excTarget, eTgt);
  endtask

  task automatic doReq(logic ae, logic h, logic [1:0] way, logic v, logic d,
                       logic w, logic lt, logic [31:0] va, logic [7:0] asid,
                       logic [31:0] pc, logic [31:0] sr, logic [31:0] vb);
    int k;
    logic tk;
    string tag;
    @(negedge clk);
    addrErr = ae; hitFlag = h; hitWay = way; entryValid = v; entryDirty = d;
    isWrite = w; loopTail = lt; vAddr = va; curAsid = asid; curPc = pc;
    curSr = sr; vecBase = vb; reqValid = 1;
    k  = classify(ae, h, v, d, w);
    tk = (k != 0) && !sr[28];
    tag = (k == 0) ? "R13" : sr[28] ? "R12" :
          (lt && k != 4) ? "R8" : (k == 3) ? "R2" : (k == 4) ? "R3" : "R4";
    if (tk) begin
      logic tail;
      tail   = lt && (k != 4);
      eFault = va;
      eSr    = sr;
      eSrOut = sr | 32'h7000_0000;
      eTgt   = vb + 32'h100;
      ePc    = tail ? (pc | 32'h1) : pc;
      if (k != 1) ePte = {va[31:10], 2'b00, asid};
      if (k == 3 || k == 4) eWay = way;
      if (tail) eCode = 12'h070;
      else case (k)
        1: eCode = w ? 12'h100 : 12'h0E0;
        2, 3: eCode = w ? 12'h060 : 12'h040;
        default: eCode = 12'h080;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    chk({tag, " excTaken"}, {31'h0, excTaken}, {31'h0, tk});
    checkAll(tag);
    @(posedge clk);
    @(negedge clk);
    chk("R11 pulse end", {31'h0, excTaken}, 32'h0);
  endtask

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 excTaken", {31'h0, excTaken}, 32'h0);
    checkAll("R1");
    rst_n = 1;

    // directed corners
    doReq(0,1,2'd2,0,0,0,0,32'h1234_5678,8'hA5,32'h8000_0100,32'h0,32'h8C00_0000); // R2 read
    doReq(0,1,2'd1,0,1,1,0,32'hFFFF_FC00,8'h3C,32'h8000_0200,32'h1,32'h8C00_0000); // R2 write
    doReq(0,1,2'd3,1,0,1,0,32'h0040_07FF,8'h11,32'h8000_0300,32'h0,32'hFFFF_FF80); // R3 + wrap R10
    doReq(0,1,2'd0,1,0,0,0,32'hDEAD_BEEF,8'h22,32'h8000_0400,32'h0,32'h0);          // R3 read clean: none
    doReq(1,0,2'd1,0,0,1,0,32'hCAFE_0001,8'h33,32'h8000_0500,32'h0,32'h100);        // R4 addr err over miss, R6/R7 hold
    doReq(0,0,2'd2,0,0,0,0,32'h0BAD_F00D,8'h44,32'h8000_0600,32'h0,32'h100);        // R4 miss over invalid, R7 hold
    doReq(0,1,2'd1,0,0,0,1,32'h7777_0000,8'h55,32'h8000_0702,32'h0,32'h200);        // R8 invalid in loop tail
    doReq(0,1,2'd3,1,0,1,1,32'h6666_0000,8'h66,32'h8000_0802,32'h0,32'h200);        // R8 clean write ignores tail
    doReq(0,1,2'd2,0,0,1,0,32'h5555_0000,8'h77,32'h8000_0900,32'h1000_0000,32'h0);  // R12 blocked
    // R11: request held across the pulse cycle is ignored the second time
    @(negedge clk);
    addrErr = 0; hitFlag = 1; hitWay = 2'd1; entryValid = 0; isWrite = 0;
    loopTail = 0; vAddr = 32'h1111_2222; curSr = 0; reqValid = 1;
    @(posedge clk); @(negedge clk);
    chk("R11 first pulse", {31'h0, excTaken}, 32'h1);
    vAddr = 32'h3333_4444;
    @(posedge clk); @(negedge clk);
    reqValid = 0;
    chk("R11 no second pulse", {31'h0, excTaken}, 32'h0);
    chk("R11 held request ignored", faultAddr, 32'h1111_2222);
    eFault = 32'h1111_2222; eSr = 0; eSrOut = 32'h7000_0000; eTgt = vecBase + 32'h100;
    ePc = curPc; ePte = {vAddr[31:10] & 22'h0, 10'h0} | {32'h1111_2222 & 32'hFFFF_FC00} | {24'h0, curAsid};
    eWay = 2'd1; eCode = 12'h040;
    @(posedge clk);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      doReq(r[3:0] == 0, r[7:4] != 0, r[9:8], r[13:10] != 0, r[14], r[15],
            r[18:16] == 0, $urandom, 8'($urandom), $urandom & 32'hFFFF_FFFE,
            ($urandom & 32'h8FFF_FFFF) | ((r[22:20] == 0) ? 32'h1000_0000 : 32'h0),
            $urandom);
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule